// File: doc/BRIEF.md
# Iterative SRT Floating-Point Divider

This block divides one double-precision floating-point number by another over several clock cycles. A single-cycle start pulse loads two operands, each given as a sign bit, an 11-bit biased exponent and a 52-bit fraction with a hidden leading one. The quotient comes back in the same three fields, together with a one-cycle done strobe and three exception flags. The quotient sign is the XOR of the operand signs. The quotient exponent is the dividend exponent minus the divisor exponent, with the bias added back in.

The significands are handled as normalized fractions. If the dividend significand is not smaller than the divisor significand, the dividend is first shifted right one place and the exponent is raised by one. This keeps the mantissa quotient below one. A radix-2 SRT recurrence then produces one signed quotient digit per cycle. Digits are selected from the top bits of the doubled partial remainder. Positive and negative digits go into separate registers. A fix-up cycle subtracts the two registers, corrects a negative final remainder, and a rounding cycle applies round-to-nearest-even.

Zero, infinity and NaN operands are recognised from their exponent fields and override the numeric path. Subnormal values are not supported: an exponent field of zero always means zero, and results below the normal range are flushed to zero.

Top module: `fpdiv_srt`

## Requirements
- R1: While reset is low, and after it until the first result, done, every quotient field and all three flags are zero.
- R2: done is high for exactly one cycle, on the 58th rising edge after the edge that samples start in the idle state. The quotient and the flags change only together with that strobe and then hold their values.
- R3: A start pulse that arrives while a division is in progress has no effect: that division's result and timing are unchanged.
- R4: For normal operands whose quotient lies in the normal range, the sign is the XOR of the operand signs and the result equals the correctly rounded IEEE double-precision quotient.
- R5: When the dividend significand is greater than or equal to the divisor significand, the dividend is aligned first. Equal significands give fraction 0 and biased exponent expA - expB + 1023.
- R6: An inexact quotient is rounded to nearest, with ties to even, using guard, round and sticky bits. The sticky bit includes a nonzero final remainder.
- R7: A finite nonzero dividend divided by zero gives an infinity (exponent field 2047, fraction 0) with the XOR sign, and sets both infFlag and dzFlag.
- R8: 0/0, infinity/infinity, or any NaN operand gives sign 0, exponent field 2047 and fraction with only bit 51 set. nanFlag is set and the other flags are clear.
- R9: An infinite dividend divided by a finite divisor gives a signed infinity with infFlag set and dzFlag clear.
- R10: A zero dividend with a finite divisor, or a finite dividend with an infinite divisor, gives a signed zero with all flags clear.
- R11: A rounded biased exponent of 2047 or more gives a signed infinity with infFlag set. A biased exponent of 0 or less gives a signed zero with no flag.
- R12: An operand with exponent field 0 is taken as zero whatever its fraction holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division; sampled only when idle |
| signA | input | 1 | Dividend sign |
| expA | input | 11 | Dividend biased exponent |
| mantA | input | 52 | Dividend fraction |
| signB | input | 1 | Divisor sign |
| expB | input | 11 | Divisor biased exponent |
| mantB | input | 52 | Divisor fraction |
| done | output | 1 | One-cycle result strobe |
| signQ | output | 1 | Quotient sign |
| expQ | output | 11 | Quotient biased exponent |
| mantQ | output | 52 | Quotient fraction |
| nanFlag | output | 1 | Result is NaN |
| infFlag | output | 1 | Result is infinite |
| dzFlag | output | 1 | Division of a finite nonzero value by zero |

## Verification
Every result falls due at a fixed point: 58 rising edges after the edge that samples start. The edge that loads the operands is followed by 56 digit iterations, then one fix-up cycle and one rounding cycle. The bench drives inputs on falling edges and counts falling edges from the one that follows the sampling edge. It requires done to be seen at exactly count 58 and to be gone one cycle later, and it reads the quotient fields at count 58. Numeric results are compared bit for bit with the host's own double-precision division.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;
  parameter int EXP_W   = 11;
  parameter int FRAC_W  = 52;
  parameter int SIG_W   = FRAC_W + 1;
  parameter int REM_F   = FRAC_W + 2;
  parameter int REM_W   = REM_F + 3;
  parameter int QUO_W   = FRAC_W + 4;
  parameter int EXT_W   = EXP_W + 2;
  parameter int BIAS    = (1 << (EXP_W - 1)) - 1;
  parameter int EXP_MAX = (1 << EXP_W) - 1;
  parameter int NITER   = QUO_W;
  parameter int CNT_W   = $clog2(NITER);

  typedef struct packed {
    logic load;
    logic step;
    logic fix;
    logic finish;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ITER,
    ST_FIX,
    ST_RND
  } divState_t;
endpackage

// File: rtl/fpdiv_ctrl.sv
module fpdiv_ctrl
  import fpdiv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output ctrlStrobe_t strobe,
  output logic        done
);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(NITER - 1);

  divState_t        state;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    strobe.load   = (state == ST_IDLE) && start;
    strobe.step   = (state == ST_ITER);
    strobe.fix    = (state == ST_FIX);
    strobe.finish = (state == ST_RND);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= strobe.finish;
      unique case (state)
        ST_IDLE: if (start) begin
          state   <= ST_ITER;
          stepCnt <= '0;
        end
        ST_ITER: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST_STEP) state <= ST_FIX;
        end
        ST_FIX:  state <= ST_RND;
        ST_RND:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpdiv_dp.sv
module fpdiv_dp
  import fpdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              signA,
  input  logic [EXP_W-1:0]  expA,
  input  logic [FRAC_W-1:0] mantA,
  input  logic              signB,
  input  logic [EXP_W-1:0]  expB,
  input  logic [FRAC_W-1:0] mantB,
  output logic              signQ,
  output logic [EXP_W-1:0]  expQ,
  output logic [FRAC_W-1:0] mantQ,
  output logic              nanFlag,
  output logic              infFlag,
  output logic              dzFlag
);
  localparam logic [EXP_W-1:0]  EXP_ONES = '1;
  localparam logic [FRAC_W-1:0] QNAN_FRAC = FRAC_W'(1) << (FRAC_W - 1);

  // operand classification
  logic aZero, aInf, aNan, bZero, bInf, bNan;
  logic isNan, isInf, isDz, isZero;
  always_comb begin
    aZero  = (expA == '0);
    bZero  = (expB == '0);
    aInf   = (expA == EXP_ONES) && (mantA == '0);
    bInf   = (expB == EXP_ONES) && (mantB == '0);
    aNan   = (expA == EXP_ONES) && (mantA != '0);
    bNan   = (expB == EXP_ONES) && (mantB != '0);
    isNan  = aNan || bNan || (aZero && bZero) || (aInf && bInf);
    isInf  = !isNan && (aInf || bZero);
    isDz   = !isNan && bZero && !aInf;
    isZero = !isNan && !isInf && (aZero || bInf);
  end

  // initial phase: sign, exponent and dividend alignment
  logic [SIG_W-1:0]            sigA, sigB;
  logic                        align;
  logic [REM_W-1:0]            remLoad, divLoad;
  logic signed [EXT_W-1:0]     expLoad;
  always_comb begin
    sigA    = {~aZero, mantA};
    sigB    = {~bZero, mantB};
    align   = (sigA >= sigB);
    remLoad = align ? REM_W'(sigA) : REM_W'({sigA, 1'b0});
    divLoad = REM_W'({sigB, 1'b0});
    expLoad = $signed({2'b00, expA}) - $signed({2'b00, expB})
            + $signed(EXT_W'(BIAS - 1)) + $signed({{(EXT_W-1){1'b0}}, align});
  end

  // working registers
  logic                    signR, nanR, infR, dzR, zeroR, remNz;
  logic signed [EXT_W-1:0] expR;
  logic [REM_W-1:0]        remR, divR;
  logic [QUO_W-1:0]        qPos, qNeg, qFin;

  // SRT step: digit from the top bits of twice the partial remainder
  logic [REM_W-1:0] twoR, remStep, remAdj;
  logic [3:0]       topBits;
  logic             digPos, digNeg;
  always_comb begin
    twoR    = {remR[REM_W-2:0], 1'b0};
    topBits = twoR[REM_W-1 -: 4];
    digPos  = $signed(topBits) > 4'sd0;
    digNeg  = $signed(topBits) < -4'sd1;
    if (digPos)      remStep = twoR - divR;
    else if (digNeg) remStep = twoR + divR;
    else             remStep = twoR;
    remAdj  = remR + divR;
  end

  // rounding phase
  logic [SIG_W-1:0]        keepBits;
  logic                    guardB, stickyB, roundUp, carry, ovf, unf;
  logic [SIG_W:0]          sumR;
  logic signed [EXT_W-1:0] expFin;
  always_comb begin
    keepBits = qFin[QUO_W-1 -: SIG_W];
    guardB   = qFin[2];
    stickyB  = (|qFin[1:0]) || remNz;
    roundUp  = guardB && (stickyB || keepBits[0]);
    sumR     = {1'b0, keepBits} + {{SIG_W{1'b0}}, roundUp};
    carry    = sumR[SIG_W];
    expFin   = expR + $signed({{(EXT_W-1){1'b0}}, carry});
    ovf      = $signed(expFin) >= $signed(EXT_W'(EXP_MAX));
    unf      = expFin[EXT_W-1] || (expFin == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      signR <= 1'b0; nanR <= 1'b0; infR <= 1'b0; dzR <= 1'b0; zeroR <= 1'b0;
      remNz <= 1'b0; expR <= '0; remR <= '0; divR <= '0;
      qPos <= '0; qNeg <= '0; qFin <= '0;
      signQ <= 1'b0; expQ <= '0; mantQ <= '0;
      nanFlag <= 1'b0; infFlag <= 1'b0; dzFlag <= 1'b0;
    end else begin
      if (strobe.load) begin
        signR <= signA ^ signB;
        nanR  <= isNan;
        infR  <= isInf;
        dzR   <= isDz;
        zeroR <= isZero;
        expR  <= expLoad;
        remR  <= remLoad;
        divR  <= divLoad;
        qPos  <= '0;
        qNeg  <= '0;
      end
      if (strobe.step) begin
        remR <= remStep;
        qPos <= {qPos[QUO_W-2:0], digPos};
        qNeg <= {qNeg[QUO_W-2:0], digNeg};
      end
      if (strobe.fix) begin
        if (remR[REM_W-1]) begin
          qFin  <= qPos - qNeg - QUO_W'(1);
          remNz <= |remAdj;
        end else begin
          qFin  <= qPos - qNeg;
          remNz <= |remR;
        end
      end
      if (strobe.finish) begin
        nanFlag <= nanR;
        dzFlag  <= dzR;
        if (nanR) begin
          signQ <= 1'b0; expQ <= EXP_ONES; mantQ <= QNAN_FRAC; infFlag <= 1'b0;
        end else if (infR || (!zeroR && ovf)) begin
          signQ <= signR; expQ <= EXP_ONES; mantQ <= '0; infFlag <= 1'b1;
        end else if (zeroR || unf) begin
          signQ <= signR; expQ <= '0; mantQ <= '0; infFlag <= 1'b0;
        end else begin
          signQ   <= signR;
          expQ    <= expFin[EXP_W-1:0];
          mantQ   <= carry ? '0 : sumR[FRAC_W-1:0];
          infFlag <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/fpdiv_srt.sv
module fpdiv_srt
  import fpdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              signA,
  input  logic [EXP_W-1:0]  expA,
  input  logic [FRAC_W-1:0] mantA,
  input  logic              signB,
  input  logic [EXP_W-1:0]  expB,
  input  logic [FRAC_W-1:0] mantB,
  output logic              done,
  output logic              signQ,
  output logic [EXP_W-1:0]  expQ,
  output logic [FRAC_W-1:0] mantQ,
  output logic              nanFlag,
  output logic              infFlag,
  output logic              dzFlag
);
  ctrlStrobe_t strobe;

  fpdiv_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .done   (done)
  );

  fpdiv_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .signA   (signA),
    .expA    (expA),
    .mantA   (mantA),
    .signB   (signB),
    .expB    (expB),
    .mantB   (mantB),
    .signQ   (signQ),
    .expQ    (expQ),
    .mantQ   (mantQ),
    .nanFlag (nanFlag),
    .infFlag (infFlag),
    .dzFlag  (dzFlag)
  );
endmodule

// File: rtl/fpdiv_srt_chk.sv
module fpdiv_srt_chk
  import fpdiv_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              done,
  input logic              signQ,
  input logic [EXP_W-1:0]  expQ,
  input logic [FRAC_W-1:0] mantQ,
  input logic              nanFlag,
  input logic              infFlag,
  input logic              dzFlag
);
  localparam logic [EXP_W-1:0]  EXP_ONES  = '1;
  localparam logic [FRAC_W-1:0] QNAN_FRAC = FRAC_W'(1) << (FRAC_W - 1);

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(expQ) && $stable(mantQ) && $stable(signQ)
               && $stable(nanFlag) && $stable(infFlag) && $stable(dzFlag)));

  assert_nan_code_R8: assert property (@(posedge clk) disable iff (!rstN)
    nanFlag |-> (expQ == EXP_ONES && mantQ == QNAN_FRAC && !signQ && !infFlag && !dzFlag));

  assert_dz_is_inf_R7: assert property (@(posedge clk) disable iff (!rstN)
    dzFlag |-> (infFlag && expQ == EXP_ONES && mantQ == '0));

  assert_inf_code_R11: assert property (@(posedge clk) disable iff (!rstN)
    infFlag |-> (expQ == EXP_ONES && mantQ == '0 && !nanFlag));
endmodule

bind fpdiv_srt fpdiv_srt_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .done    (done),
  .signQ   (signQ),
  .expQ    (expQ),
  .mantQ   (mantQ),
  .nanFlag (nanFlag),
  .infFlag (infFlag),
  .dzFlag  (dzFlag)
);

// File: tb/fpdiv_srt_bench.sv
module fpdiv_srt_bench;
  localparam int LATENCY = 58;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        signA = 1'b0, signB = 1'b0;
  logic [10:0] expA = '0, expB = '0;
  logic [51:0] mantA = '0, mantB = '0;
  logic        done, signQ, nanFlag, infFlag, dzFlag;
  logic [10:0] expQ;
  logic [51:0] mantQ;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fpdiv_srt u_fpdiv_srt (
    .clk(clk), .rstN(rstN), .start(start),
    .signA(signA), .expA(expA), .mantA(mantA),
    .signB(signB), .expB(expB), .mantB(mantB),
    .done(done), .signQ(signQ), .expQ(expQ), .mantQ(mantQ),
    .nanFlag(nanFlag), .infFlag(infFlag), .dzFlag(dzFlag)
  );

  logic [63:0] resBits;
  logic [2:0]  resFlags;
  int          resLat;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic driveOps(input logic [63:0] a, input logic [63:0] b);
    signA = a[63]; expA = a[62:52]; mantA = a[51:0];
    signB = b[63]; expB = b[62:52]; mantB = b[51:0];
  endtask

  // start a division, count edges to done, capture outputs, check timing (R2)
  task automatic runDiv(input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    driveOps(a, b);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    resLat = 0;
    while (!done && resLat < 500) begin
      @(negedge clk);
      resLat++;
    end
    resBits  = {signQ, expQ, mantQ};
    resFlags = {nanFlag, infFlag, dzFlag};
    check("R2 latency", 64'(resLat), 64'(LATENCY));
    @(negedge clk);
    check("R2 single-cycle done", 64'(done), 64'(0));
    check("R2 result held", {signQ, expQ, mantQ}, resBits);
  endtask

  function automatic logic [63:0] refDiv(input logic [63:0] a, input logic [63:0] b);
    return $realtobits($bitstoreal(a) / $bitstoreal(b));
  endfunction

  task automatic numeric(input string req, input real x, input real y);
    logic [63:0] a, b;
    a = $realtobits(x);
    b = $realtobits(y);
    runDiv(a, b);
    check(req, resBits, refDiv(a, b));
    check({req, " flags"}, 64'(resFlags), 64'(0));
  endtask

  task automatic testReset();
    check("R1 reset outputs", {61'(0), done, nanFlag, infFlag}, 64'(0));
    check("R1 reset quotient", {signQ, expQ, mantQ}, 64'(0));
    check("R1 reset dz", 64'(dzFlag), 64'(0));
  endtask

  task automatic testValues();
    numeric("R4 basic", 243.0, 234.0);
    numeric("R4 sign", -7.5, 2.5);
    numeric("R4 both negative", -1.0e10, -3.7);
    numeric("R6 one third", 1.0, 3.0);
    numeric("R6 two thirds", 2.0, 3.0);
    numeric("R6 tenth", 1.0, 10.0);
    numeric("R6 big range", 1.0e200, 7.0e-50);
  endtask

  task automatic testAlign();
    runDiv($realtobits(6.0), $realtobits(3.0));
    check("R5 equal significands", resBits, {1'b0, 11'(1024), 52'(0)});
    runDiv($realtobits(3.0), $realtobits(1.0));
    check("R5 greater significand", resBits, $realtobits(3.0));
  endtask

  task automatic testRandom();
    logic [63:0] s = 64'h1234_5678_9abc_def1;
    for (int i = 0; i < 24; i++) begin
      logic [63:0] a, b;
      s = s * 64'd6364136223846793005 + 64'd1442695040888963407;
      a = {s[63], 11'(1023 - 100) + 11'(s[7:0]), s[59:8]};
      s = s * 64'd6364136223846793005 + 64'd1442695040888963407;
      b = {s[63], 11'(1023 - 100) + 11'(s[7:0]), s[59:8]};
      runDiv(a, b);
      check("R6 varied operands", resBits, refDiv(a, b));
    end
  endtask

  task automatic testBusy();
    logic [63:0] a = $realtobits(5.0), b = $realtobits(4.0);
    @(negedge clk);
    driveOps(a, b);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    resLat = 0;
    repeat (9) begin @(negedge clk); resLat++; end
    driveOps($realtobits(9.0), $realtobits(0.0));
    start = 1'b1;
    @(negedge clk); resLat++;
    start = 1'b0;
    while (!done && resLat < 500) begin @(negedge clk); resLat++; end
    check("R3 timing unchanged", 64'(resLat), 64'(LATENCY));
    check("R3 result unchanged", {signQ, expQ, mantQ}, refDiv(a, b));
    check("R3 flags unchanged", {61'(0), nanFlag, infFlag, dzFlag}, 64'(0));
    repeat (LATENCY + 4) begin
      @(negedge clk);
      if (done) check("R3 no second result", 64'(done), 64'(0));
    end
  endtask

  task automatic testSpecials();
    logic [63:0] inf = {1'b0, 11'h7FF, 52'(0)};
    logic [63:0] nanV = {1'b0, 11'h7FF, 52'h8_0000_0000_1234};
    logic [63:0] qnan = {1'b0, 11'h7FF, 52'h8_0000_0000_0000};
    runDiv($realtobits(-3.0), 64'(0));
    check("R7 div by zero value", resBits, {1'b1, 11'h7FF, 52'(0)});
    check("R7 div by zero flags", 64'(resFlags), 64'(3'b011));
    runDiv(64'(0), {1'b1, 63'(0)});
    check("R8 zero over zero", resBits, qnan);
    check("R8 zero over zero flags", 64'(resFlags), 64'(3'b100));
    runDiv(inf, {1'b1, inf[62:0]});
    check("R8 inf over inf", resBits, qnan);
    runDiv($realtobits(2.0), nanV);
    check("R8 nan operand", resBits, qnan);
    check("R8 nan operand flags", 64'(resFlags), 64'(3'b100));
    runDiv({1'b1, inf[62:0]}, $realtobits(4.0));
    check("R9 inf dividend", resBits, {1'b1, 11'h7FF, 52'(0)});
    check("R9 inf dividend flags", 64'(resFlags), 64'(3'b010));
    runDiv(64'(0), $realtobits(-5.0));
    check("R10 zero dividend", resBits, {1'b1, 63'(0)});
    check("R10 zero dividend flags", 64'(resFlags), 64'(0));
    runDiv($realtobits(5.0), inf);
    check("R10 inf divisor", resBits, 64'(0));
  endtask

  task automatic testRange();
    runDiv({1'b0, 11'd2023, 52'(0)}, {1'b1, 11'd923, 52'(0)});
    check("R11 overflow", resBits, {1'b1, 11'h7FF, 52'(0)});
    check("R11 overflow flags", 64'(resFlags), 64'(3'b010));
    runDiv({1'b0, 11'd23, 52'(0)}, {1'b0, 11'd1123, 52'(0)});
    check("R11 underflow", resBits, 64'(0));
    check("R11 underflow flags", 64'(resFlags), 64'(0));
  endtask

  task automatic testSubnormalInput();
    runDiv({1'b0, 11'd0, 52'h0_0000_0000_00FF}, $realtobits(2.0));
    check("R12 tiny dividend is zero", resBits, 64'(0));
    runDiv($realtobits(1.0), {1'b0, 11'd0, 52'h1});
    check("R12 tiny divisor is zero", resBits, {1'b0, 11'h7FF, 52'(0)});
    check("R12 tiny divisor flags", 64'(resFlags), 64'(3'b011));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testValues();
    testAlign();
    testRandom();
    testBusy();
    testSpecials();
    testRange();
    testSubnormalInput();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule